// File: doc/BRIEF.md
# Branch and Call Control Sequencer

This block sits at the decode point of a small 16-bit instruction pipeline. It handles the instructions that move the program counter. It decodes conditional and unconditional relative branches, relative and absolute calls, absolute jumps, the three return forms, and explicit push and pop of a hardware return stack. For each word it accepts, it computes the next byte-addressed program counter. All other words advance the counter by one word (two bytes).

The fetch side presents one instruction word per cycle with a valid strobe, together with the current condition flags. When a transfer is taken, the following presented word is treated as a forced no-operation slot and discarded. Absolute call and jump take two words. Their second word carries the upper target bits. Side effects leave the block as single-cycle pulses:
- stack push and pop,
- working-register literal load,
- interrupt re-enable,
- reset request,
- context restore.

Top module: `ctl_seq`

## Requirements
- R1: While reset is held, and after it is released, `pc_o` is 0, `flush_o` is 0, every pulse output is 0, and both sticky stack flags are 0.
- R2: The sequencer accepts a word on any clock edge where `valid_i` is high. Every output updates at that edge, and pulse outputs stay high for exactly one cycle. A word that is neither a transfer nor a stack operation advances `pc_o` by 2. A cycle with `valid_i` low changes nothing.
- R3: Conditional branches use the form 1110 0ccc followed by an 8-bit signed offset. The code ccc selects the tested flag and its sense:
  - 000 tests Z set, 001 tests Z clear;
  - 010 tests C set, 011 tests C clear;
  - 100 tests OV set, 101 tests OV clear;
  - 110 tests N set, 111 tests N clear.
  When the condition holds, `pc_o` becomes pc+2+2*offset and `flush_o` rises. When it does not hold, `pc_o` becomes pc+2 and `flush_o` stays low.
- R4: The form 1101 0 followed by an 11-bit signed offset always branches to pc+2+2*offset and raises `flush_o`. The form 1101 1 does the same and also pushes pc+2.
- R5: First words 1110 110s (call) and 1110 1111 (jump) carry 8 low target bits and advance the pc by 2. The next accepted word is consumed as the second word. Its low 12 bits form the target {w2[11:0], w1[7:0], 0}, and `flush_o` rises. A call also pushes the address that follows the second word.
- R6: A word whose top nibble is 1111, when not consumed as a second word, acts as a no-operation and advances the pc by 2.
- R7: A word accepted while `flush_o` is high is ignored. The pc does not change, no pulse is raised, and `flush_o` falls.
- R8: The following three instructions set `pc_o` to the top of the stack, pop it, and raise `flush_o`:
  - 0x0012/0x0013 is a return;
  - 0x0010/0x0011 is a return that also pulses `int_en_set_o`;
  - 0x0C kk is a return that pulses `lit_load_o` with `lit_o` = kk.
- R9: Word 0x0005 pushes pc+2. Word 0x0006 discards the top entry. Both advance the pc by 2 and neither raises `flush_o`.
- R10: The return stack holds 31 entries. A push while full sets `stk_ovf_o` and stores nothing. A pop while empty sets `stk_unf_o` and returns address 0. Both flags stay set until reset.
- R11: A call whose s bit (bit 8 of the first word) is 1 captures `ctx_i` into `ctx_o` when its second word is accepted. A return or interrupt return with bit 0 set pulses `ctx_restore_o`.
- R12: Word 0x00FF pulses `reset_req_o` and advances the pc by 2. Any other unlisted word is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 16 | Instruction word |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_z_i | input | 1 | Zero flag |
| ctx_i | input | CTX_W | Working register, status and bank context to shadow |
| pc_o | output | PC_W | Byte address of the next expected word |
| flush_o | output | 1 | Next accepted word is a discarded slot |
| stk_push_o | output | 1 | Push requested this cycle |
| stk_pop_o | output | 1 | Pop requested this cycle |
| lit_load_o | output | 1 | Load `lit_o` into the working register |
| lit_o | output | 8 | Literal for the working register |
| int_en_set_o | output | 1 | Re-enable global interrupts |
| reset_req_o | output | 1 | Software reset request |
| ctx_restore_o | output | 1 | Restore context from `ctx_o` |
| ctx_o | output | CTX_W | Shadowed context |
| stk_ovf_o | output | 1 | Sticky stack overflow |
| stk_unf_o | output | 1 | Sticky stack underflow |

## Verification
Every result of an accepted word is due exactly one edge after acceptance: the new pc, the flush flag and each pulse all come from a single register stage. The driver therefore queues the expected item in the same cycle it presents the word. The monitor pops that item one nanosecond after the next rising edge, but only if `valid_i` was high at that edge. The discarded slot and the second word of a two-word instruction each get their own queued item, so each lands in its own cycle. The shadowed context and the sticky flags are checked directly at falling edges during idle cycles.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_BCC,
        OP_BRA,
        OP_RCALL,
        OP_CALL1,
        OP_GOTO1,
        OP_RET,
        OP_RETFIE,
        OP_RETLW,
        OP_PUSH,
        OP_POP,
        OP_SWRST
    } op_e;

endpackage

// File: rtl/ctl_seq_dec.sv
module ctl_seq_dec
    import ctl_seq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic [15:0]     instr_i,
    input  logic            flag_c_i,
    input  logic            flag_n_i,
    input  logic            flag_ov_i,
    input  logic            flag_z_i,
    output op_e             op_o,
    output logic            taken_o,
    output logic            sbit_o,
    output logic [PC_W-1:0] rel_o
);

    logic flag_sel;

    always_comb begin
        op_o    = OP_NOP;
        taken_o = 1'b0;
        sbit_o  = instr_i[0];
        rel_o   = '0;
        case (instr_i[10:9])
            2'd0:    flag_sel = flag_z_i;
            2'd1:    flag_sel = flag_c_i;
            2'd2:    flag_sel = flag_ov_i;
            default: flag_sel = flag_n_i;
        endcase
        if (instr_i[15:11] == 5'b11100) begin
            op_o    = OP_BCC;
            taken_o = flag_sel ^ instr_i[8];
            rel_o   = {{(PC_W-9){instr_i[7]}}, instr_i[7:0], 1'b0};
        end else if (instr_i[15:11] == 5'b11010) begin
            op_o  = OP_BRA;
            rel_o = {{(PC_W-12){instr_i[10]}}, instr_i[10:0], 1'b0};
        end else if (instr_i[15:11] == 5'b11011) begin
            op_o  = OP_RCALL;
            rel_o = {{(PC_W-12){instr_i[10]}}, instr_i[10:0], 1'b0};
        end else if (instr_i[15:9] == 7'b1110110) begin
            op_o   = OP_CALL1;
            sbit_o = instr_i[8];
        end else if (instr_i[15:8] == 8'hEF) begin
            op_o = OP_GOTO1;
        end else if (instr_i[15:8] == 8'h0C) begin
            op_o = OP_RETLW;
        end else if (instr_i[15:1] == 15'h0009) begin
            op_o = OP_RET;
        end else if (instr_i[15:1] == 15'h0008) begin
            op_o = OP_RETFIE;
        end else if (instr_i == 16'h0005) begin
            op_o = OP_PUSH;
        end else if (instr_i == 16'h0006) begin
            op_o = OP_POP;
        end else if (instr_i == 16'h00FF) begin
            op_o = OP_SWRST;
        end
    end

endmodule

// File: rtl/ctl_seq_stack.sv
module ctl_seq_stack #(
    parameter int DEPTH = 31,
    parameter int W     = 21
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] tos_o,
    output logic         full_o,
    output logic         empty_o
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;

    assign full_o  = (ptr_q == PTR_W'(DEPTH));
    assign empty_o = (ptr_q == '0);
    assign tos_o   = empty_o ? '0 : mem[ptr_q - PTR_W'(1)];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (push_i && !full_o) begin
            mem[ptr_q] <= data_i;
            ptr_q      <= ptr_q + PTR_W'(1);
        end else if (pop_i && !empty_o) begin
            ptr_q <= ptr_q - PTR_W'(1);
        end
    end

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_seq_pkg::*;
#(
    parameter int PC_W      = 21,
    parameter int STK_DEPTH = 31,
    parameter int CTX_W     = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [15:0]      instr_i,
    input  logic             flag_c_i,
    input  logic             flag_n_i,
    input  logic             flag_ov_i,
    input  logic             flag_z_i,
    input  logic [CTX_W-1:0] ctx_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             flush_o,
    output logic             stk_push_o,
    output logic             stk_pop_o,
    output logic             lit_load_o,
    output logic [7:0]       lit_o,
    output logic             int_en_set_o,
    output logic             reset_req_o,
    output logic             ctx_restore_o,
    output logic [CTX_W-1:0] ctx_o,
    output logic             stk_ovf_o,
    output logic             stk_unf_o
);

    localparam logic [PC_W-1:0] WORD_STEP = PC_W'(2);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic             flush;
        logic             two;
        logic             two_call;
        logic             two_s;
        logic [7:0]       two_lo;
        logic             ovf;
        logic             unf;
        logic [CTX_W-1:0] shadow;
        logic             push_p;
        logic             pop_p;
        logic             lit_p;
        logic [7:0]       lit;
        logic             ien_p;
        logic             rst_p;
        logic             rest_p;
    } state_t;

    state_t d, q;

    op_e             op;
    logic            taken;
    logic            sbit;
    logic [PC_W-1:0] rel;
    logic [PC_W-1:0] seq_pc;
    logic            st_push, st_pop, st_full, st_empty;
    logic [PC_W-1:0] st_data, st_tos;

    ctl_seq_dec #(.PC_W(PC_W)) i_dec (
        .instr_i  (instr_i),
        .flag_c_i (flag_c_i),
        .flag_n_i (flag_n_i),
        .flag_ov_i(flag_ov_i),
        .flag_z_i (flag_z_i),
        .op_o     (op),
        .taken_o  (taken),
        .sbit_o   (sbit),
        .rel_o    (rel)
    );

    ctl_seq_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) i_stack (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (st_push),
        .pop_i  (st_pop),
        .data_i (st_data),
        .tos_o  (st_tos),
        .full_o (st_full),
        .empty_o(st_empty)
    );

    assign seq_pc = q.pc + WORD_STEP;

    always_comb begin
        d        = q;
        d.push_p = 1'b0;
        d.pop_p  = 1'b0;
        d.lit_p  = 1'b0;
        d.ien_p  = 1'b0;
        d.rst_p  = 1'b0;
        d.rest_p = 1'b0;
        st_push  = 1'b0;
        st_pop   = 1'b0;
        st_data  = seq_pc;
        if (valid_i) begin
            if (q.flush) begin
                // discarded slot after a taken transfer
                d.flush = 1'b0;
            end else if (q.two) begin
                d.two   = 1'b0;
                d.flush = 1'b1;
                d.pc    = PC_W'({instr_i[11:0], q.two_lo, 1'b0});
                if (q.two_call) begin
                    st_push = 1'b1;
                    if (q.two_s) d.shadow = ctx_i;
                end
            end else begin
                d.pc = seq_pc;
                case (op)
                    OP_BCC: begin
                        if (taken) begin
                            d.pc    = seq_pc + rel;
                            d.flush = 1'b1;
                        end
                    end
                    OP_BRA: begin
                        d.pc    = seq_pc + rel;
                        d.flush = 1'b1;
                    end
                    OP_RCALL: begin
                        d.pc    = seq_pc + rel;
                        d.flush = 1'b1;
                        st_push = 1'b1;
                    end
                    OP_CALL1, OP_GOTO1: begin
                        d.two      = 1'b1;
                        d.two_call = (op == OP_CALL1);
                        d.two_s    = sbit;
                        d.two_lo   = instr_i[7:0];
                    end
                    OP_RET, OP_RETFIE, OP_RETLW: begin
                        d.pc    = st_tos;
                        d.flush = 1'b1;
                        st_pop  = 1'b1;
                        if (op == OP_RETLW) begin
                            d.lit_p = 1'b1;
                            d.lit   = instr_i[7:0];
                        end else begin
                            d.rest_p = sbit;
                        end
                        d.ien_p = (op == OP_RETFIE);
                    end
                    OP_PUSH:  st_push = 1'b1;
                    OP_POP:   st_pop  = 1'b1;
                    OP_SWRST: d.rst_p = 1'b1;
                    default: ;
                endcase
            end
        end
        d.push_p = st_push;
        d.pop_p  = st_pop;
        if (st_push && st_full)  d.ovf = 1'b1;
        if (st_pop  && st_empty) d.unf = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pc_o          = q.pc;
    assign flush_o       = q.flush;
    assign stk_push_o    = q.push_p;
    assign stk_pop_o     = q.pop_p;
    assign lit_load_o    = q.lit_p;
    assign lit_o         = q.lit;
    assign int_en_set_o  = q.ien_p;
    assign reset_req_o   = q.rst_p;
    assign ctx_restore_o = q.rest_p;
    assign ctx_o         = q.shadow;
    assign stk_ovf_o     = q.ovf;
    assign stk_unf_o     = q.unf;

endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk #(
    parameter int PC_W = 21
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [PC_W-1:0] pc_o,
    input logic            flush_o,
    input logic            stk_push_o,
    input logic            stk_pop_o,
    input logic            lit_load_o,
    input logic            int_en_set_o,
    input logic            reset_req_o,
    input logic            ctx_restore_o,
    input logic            stk_ovf_o,
    input logic            stk_unf_o
);

    a_r7_slot_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_o && valid_i) |=> (!flush_o && pc_o == $past(pc_o) && !stk_push_o &&
            !stk_pop_o && !lit_load_o && !int_en_set_o && !reset_req_o && !ctx_restore_o));

    a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (pc_o == $past(pc_o) && !stk_push_o && !stk_pop_o &&
            !lit_load_o && !int_en_set_o && !reset_req_o && !ctx_restore_o));

    a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stk_ovf_o |=> stk_ovf_o);

    a_r10_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stk_unf_o |=> stk_unf_o);

    a_r8_literal_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lit_load_o |-> (stk_pop_o && flush_o));

    a_r8_ien_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_en_set_o |-> (stk_pop_o && flush_o));

    a_r9_one_stack_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({stk_push_o, stk_pop_o}));

    a_r2_pc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_o[0] == 1'b0);

endmodule

bind ctl_seq ctl_seq_chk #(.PC_W(PC_W)) i_ctl_seq_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .pc_o         (pc_o),
    .flush_o      (flush_o),
    .stk_push_o   (stk_push_o),
    .stk_pop_o    (stk_pop_o),
    .lit_load_o   (lit_load_o),
    .int_en_set_o (int_en_set_o),
    .reset_req_o  (reset_req_o),
    .ctx_restore_o(ctx_restore_o),
    .stk_ovf_o    (stk_ovf_o),
    .stk_unf_o    (stk_unf_o)
);

// File: tb/test_ctl_seq.sv
module test_ctl_seq;

    localparam int PC_W  = 21;
    localparam int CTX_W = 24;
    localparam logic [5:0] P_NONE = 6'b000000;
    localparam logic [5:0] P_PUSH = 6'b100000;
    localparam logic [5:0] P_POP  = 6'b010000;
    localparam logic [5:0] P_LIT  = 6'b001000;
    localparam logic [5:0] P_IEN  = 6'b000100;
    localparam logic [5:0] P_RST  = 6'b000010;
    localparam logic [5:0] P_REST = 6'b000001;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vin = 1'b0;
    logic [15:0]      instr = '0;
    logic [3:0]       flags = '0;  // {n, ov, z, c}
    logic [CTX_W-1:0] ctx = '0;
    logic [PC_W-1:0]  pc;
    logic             flush, push, pop, litld, ien, rstreq, rest, ovf, unf;
    logic [7:0]       lit;
    logic [CTX_W-1:0] shadow;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic            flush;
        logic [5:0]      pulses;
        logic [7:0]      lit;
        string           req;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    ctl_seq i_ctl_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .valid_i      (vin),
        .instr_i      (instr),
        .flag_c_i     (flags[0]),
        .flag_n_i     (flags[3]),
        .flag_ov_i    (flags[2]),
        .flag_z_i     (flags[1]),
        .ctx_i        (ctx),
        .pc_o         (pc),
        .flush_o      (flush),
        .stk_push_o   (push),
        .stk_pop_o    (pop),
        .lit_load_o   (litld),
        .lit_o        (lit),
        .int_en_set_o (ien),
        .reset_req_o  (rstreq),
        .ctx_restore_o(rest),
        .ctx_o        (shadow),
        .stk_ovf_o    (ovf),
        .stk_unf_o    (unf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [15:0] w, input logic [3:0] f, input logic [PC_W-1:0] epc,
                        input logic efl, input logic [5:0] ep, input logic [7:0] elit,
                        input string req);
        exp_t e;
        @(negedge clk);
        instr = w;
        flags = f;
        vin   = 1'b1;
        e.pc = epc; e.flush = efl; e.pulses = ep; e.lit = elit; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        vin = 1'b0;
    endtask

    // monitor: results are due one edge after acceptance
    initial begin
        forever begin
            @(posedge clk);
            if (vin && rst_n) begin
                exp_t e;
                #1;
                if (exp_q.size() == 0) begin
                    chk("queue", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk({e.req, " pc"}, 32'(pc), 32'(e.pc));
                    chk({e.req, " flush"}, 32'(flush), 32'(e.flush));
                    chk({e.req, " pulses"}, 32'({push, pop, litld, ien, rstreq, rest}),
                        32'(e.pulses));
                    if (e.pulses[3]) chk({e.req, " literal"}, 32'(lit), 32'(e.lit));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", 32'(pc), 32'd0);
        chk("R1 outputs", 32'({flush, push, pop, litld, ien, rstreq, rest, ovf, unf}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({pc, flush, ovf, unf}), 32'd0);

        send(16'h0000, 4'h0, 21'd2, 1'b0, P_NONE, 8'h0, "R2 nop");
        idle(); idle();
        chk("R2 idle holds pc", 32'(pc), 32'd2);
        send(16'hE005, 4'h0, 21'd4, 1'b0, P_NONE, 8'h0, "R3 bz not taken");
        send(16'hE005, 4'h2, 21'd16, 1'b1, P_NONE, 8'h0, "R3 bz taken");
        send(16'h0005, 4'h0, 21'd16, 1'b0, P_NONE, 8'h0, "R7 slot ignores push");
        send(16'hE3FE, 4'h0, 21'd14, 1'b1, P_NONE, 8'h0, "R3 bnc backward");
        send(16'h0000, 4'h0, 21'd14, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'hE403, 4'h0, 21'd16, 1'b0, P_NONE, 8'h0, "R3 bov not taken");
        send(16'hE601, 4'h8, 21'd20, 1'b1, P_NONE, 8'h0, "R3 bn taken");
        send(16'h0000, 4'h0, 21'd20, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'hD80A, 4'h0, 21'd42, 1'b1, P_PUSH, 8'h0, "R4 rcall");
        send(16'h0000, 4'h0, 21'd42, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'hF123, 4'h0, 21'd44, 1'b0, P_NONE, 8'h0, "R6 stray second word");
        send(16'h0005, 4'h0, 21'd46, 1'b0, P_PUSH, 8'h0, "R9 push");
        send(16'h0006, 4'h0, 21'd48, 1'b0, P_POP, 8'h0, "R9 pop");
        send(16'hED34, 4'h0, 21'd50, 1'b0, P_NONE, 8'h0, "R5 call first word");
        ctx = 24'hA1B2C3;
        send(16'hF567, 4'h0, 21'hACE68, 1'b1, P_PUSH, 8'h0, "R5 call second word");
        @(posedge clk); #1 ctx = 24'h0;
        send(16'h0000, 4'h0, 21'hACE68, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'h0C5A, 4'h0, 21'd52, 1'b1, P_POP | P_LIT, 8'h5A, "R8 return literal");
        send(16'h0000, 4'h0, 21'd52, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'h0013, 4'h0, 21'd22, 1'b1, P_POP | P_REST, 8'h0, "R8 R11 return restore");
        idle();
        chk("R11 shadow held", 32'(shadow), 32'hA1B2C3);
        send(16'h0000, 4'h0, 21'd22, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'hEF10, 4'h0, 21'd24, 1'b0, P_NONE, 8'h0, "R5 goto first word");
        send(16'hF001, 4'h0, 21'h220, 1'b1, P_NONE, 8'h0, "R5 goto second word");
        send(16'h0000, 4'h0, 21'h220, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'h00FF, 4'h0, 21'h222, 1'b0, P_RST, 8'h0, "R12 reset request");
        send(16'h0010, 4'h0, 21'd0, 1'b1, P_POP | P_IEN, 8'h0, "R8 R10 retfie empty");
        idle();
        chk("R10 underflow set", 32'(unf), 32'd1);
        chk("R10 no overflow", 32'(ovf), 32'd0);
        send(16'h0000, 4'h0, 21'd0, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'hD7FF, 4'h0, 21'd0, 1'b1, P_NONE, 8'h0, "R4 bra backward");
        send(16'h0000, 4'h0, 21'd0, 1'b0, P_NONE, 8'h0, "R7 slot");
        for (int i = 0; i < 31; i++) begin
            send(16'h0005, 4'h0, PC_W'(2 * i + 2), 1'b0, P_PUSH, 8'h0, "R10 fill");
        end
        idle();
        chk("R10 full without overflow", 32'(ovf), 32'd0);
        send(16'h0005, 4'h0, 21'd64, 1'b0, P_PUSH, 8'h0, "R10 push when full");
        idle();
        chk("R10 overflow set", 32'(ovf), 32'd1);
        send(16'h0012, 4'h0, 21'd62, 1'b1, P_POP, 8'h0, "R10 top kept after overflow");
        send(16'h0000, 4'h0, 21'd62, 1'b0, P_NONE, 8'h0, "R7 slot");
        send(16'hEE00, 4'h0, 21'd64, 1'b0, P_NONE, 8'h0, "R12 unlisted word");
        idle(); idle();
        chk("R10 flags sticky", 32'({ovf, unf}), 32'd3);
        chk("queue drained", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule